// File: doc/BRIEF.md
# Real-Time Status Register with Interrupt

This block gathers two already-debounced detect bits per channel (a primary bit A and a secondary bit B) from a group of channels into a single status word. A host can read that word at any time. The word is registered, so it shows the channel inputs one clock later. When the host configures it, a second set of inputs replaces the secondary inputs as the source of every B bit.

An active-low interrupt tells the host that something needs attention. It asserts when an unmasked status bit changes value, or when a channel whose transmit-arm bit is set reports a transmit data change. While the interrupt is active, every unmasked bit is frozen at the value it had when the interrupt fired, so the host reads a consistent snapshot. Masked bits always keep tracking their inputs. The interrupt stays active until one of three things happens: a read with the clearing command, a write to the mask, or reset. A plain read command returns the same word and changes nothing. The host sees a change that arrived while it was servicing the interrupt as a fresh interrupt on the cycle after the clear.

Top module: `rt_status_irq`

## Requirements
- R1: Status bit 2n holds the A input of channel n and bit 2n+1 holds its B bit. While the interrupt is inactive and no clear is requested, `rd_data` equals the mapped inputs sampled at the previous clock edge.
- R2: When `alt_mode` is 0, the B bit of channel n comes from `cd_b[n]`. When `alt_mode` is 1, it comes from `cd_alt[n]`.
- R3: While reset is asserted, `rd_data` is all zeros, `irq_n` is 1 and every mask bit is 1 (all bits masked).
- R4: An unmasked bit (mask bit 0) whose mapped input differs from `rd_data` drives `irq_n` low one cycle later, provided the interrupt is inactive and no clear is requested in that cycle.
- R5: A `tx_chg[n]` pulse while `tx_arm[n]` is 1 drives `irq_n` low one cycle later, under the same conditions as R4. A pulse on an unarmed channel has no effect.
- R6: While `irq_n` is low, unmasked bits of `rd_data` hold their value and masked bits keep following their inputs with one cycle of delay.
- R7: Once low, `irq_n` stays low until a clear.
- R8: A read with `rd_stb`=1 and `rd_clear`=1 returns `irq_n` to 1 on the next cycle. A read with `rd_clear`=0 leaves both the interrupt and the status unchanged.
- R9: A write with `mask_we`=1 loads `mask_wdata` into the mask (1 = masked) and returns `irq_n` to 1 on the next cycle.
- R10: In the cycle of a clear, unmasked bits still hold. If one of them then differs from its input, `irq_n` is high for exactly one cycle and goes low again. A transmit event that arrives in the same cycle as a clear is dropped.
- R11: Changes on masked bits never drive `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cd_a | input | NCH | Debounced primary detect, one per channel |
| cd_b | input | NCH | Debounced secondary detect, one per channel |
| cd_alt | input | NCH | Debounced alternate detect, used for B when `alt_mode` is 1 |
| alt_mode | input | 1 | Selects the B-bit source |
| tx_chg | input | NCH | One-cycle pulse per channel when transmit data changes |
| tx_arm | input | NCH | Per-channel arm bit for transmit-change interrupts |
| rd_stb | input | 1 | Read request strobe |
| rd_clear | input | 1 | Read command: 1 = clearing read, 0 = plain read |
| rd_data | output | 2*NCH | Status word |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 2*NCH | New mask value, 1 = bit masked |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. The status word follows its inputs one edge later. The interrupt falls, or rises on a clear, one edge after the event. A pending difference re-raises the interrupt one edge after the clear takes effect. The bench therefore changes inputs on the falling edge, lets one rising edge pass, and compares both outputs on the following falling edge against a reference model stepped once per cycle. Directed steps add fixed expected words around freeze, plain and clearing reads, mask writes and armed or unarmed transmit events.

// File: rtl/rtsr_pkg.sv
package rtsr_pkg;

    localparam int RTSR_NCH_DEF = 4;

    typedef enum logic {
        RD_PEEK = 1'b0,
        RD_CLR  = 1'b1
    } rd_cmd_e;

endpackage

// File: rtl/rtsr_live_map.sv
module rtsr_live_map #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0]   cd_a,
    input  logic [NCH-1:0]   cd_b,
    input  logic [NCH-1:0]   cd_alt,
    input  logic             alt_mode,
    output logic [2*NCH-1:0] live
);

    // Interleave per channel: even bit = primary, odd bit = selected secondary.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic b_sel;
        assign b_sel          = alt_mode ? cd_alt[ch] : cd_b[ch];
        assign live[2*ch]     = cd_a[ch];
        assign live[2*ch + 1] = b_sel;
    end

endmodule

// File: rtl/rtsr_evt.sv
module rtsr_evt #(
    parameter int NCH = 4
) (
    input  logic [2*NCH-1:0] live,
    input  logic [2*NCH-1:0] stat_q,
    input  logic [2*NCH-1:0] mask_q,
    input  logic [NCH-1:0]   tx_chg,
    input  logic [NCH-1:0]   tx_arm,
    output logic             bit_evt,
    output logic             tx_evt
);

    localparam int W = 2*NCH;

    logic [W-1:0]   diff_unm;
    logic [NCH-1:0] tx_hit;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign diff_unm[b] = !mask_q[b] && (live[b] != stat_q[b]);
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_tx
        assign tx_hit[ch] = tx_chg[ch] && tx_arm[ch];
    end

    assign bit_evt = |diff_unm;
    assign tx_evt  = |tx_hit;

endmodule

// File: rtl/rt_status_irq.sv
module rt_status_irq
    import rtsr_pkg::*;
#(
    parameter int NCH = RTSR_NCH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   cd_a,
    input  logic [NCH-1:0]   cd_b,
    input  logic [NCH-1:0]   cd_alt,
    input  logic             alt_mode,
    input  logic [NCH-1:0]   tx_chg,
    input  logic [NCH-1:0]   tx_arm,
    input  logic             rd_stb,
    input  logic             rd_clear,
    output logic [2*NCH-1:0] rd_data,
    input  logic             mask_we,
    input  logic [2*NCH-1:0] mask_wdata,
    output logic             irq_n
);

    localparam int W = 2*NCH;

    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] mask;
        logic         irq;
    } state_t;

    state_t       st_d, st_q;
    logic [W-1:0] live;
    logic         bit_evt;
    logic         tx_evt;
    logic         clr_req;
    logic         hold;
    rd_cmd_e      cmd;

    rtsr_live_map #(.NCH(NCH)) u_map (
        .cd_a     (cd_a),
        .cd_b     (cd_b),
        .cd_alt   (cd_alt),
        .alt_mode (alt_mode),
        .live     (live)
    );

    rtsr_evt #(.NCH(NCH)) u_evt (
        .live    (live),
        .stat_q  (st_q.stat),
        .mask_q  (st_q.mask),
        .tx_chg  (tx_chg),
        .tx_arm  (tx_arm),
        .bit_evt (bit_evt),
        .tx_evt  (tx_evt)
    );

    always_comb begin
        st_d    = st_q;
        cmd     = rd_cmd_e'(rd_clear);
        clr_req = (rd_stb && (cmd == RD_CLR)) || mask_we;
        // Unmasked bits are frozen while the interrupt is up and during the
        // clearing cycle, so a pending difference re-raises it afterwards.
        hold    = st_q.irq || clr_req;

        if (hold) begin
            st_d.stat = (st_q.stat & ~st_q.mask) | (live & st_q.mask);
        end else begin
            st_d.stat = live;
        end

        if (clr_req) begin
            st_d.irq = 1'b0;
        end else if (!st_q.irq && (bit_evt || tx_evt)) begin
            st_d.irq = 1'b1;
        end

        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat <= '0;
            st_q.mask <= '1;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.stat;
    assign irq_n   = ~st_q.irq;

endmodule

// File: rtl/rtsr_chk.sv
module rtsr_chk #(
    parameter int NCH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   tx_chg,
    input logic [NCH-1:0]   tx_arm,
    input logic             rd_stb,
    input logic             rd_clear,
    input logic             mask_we,
    input logic [2*NCH-1:0] rd_data,
    input logic             irq_n,
    input logic [2*NCH-1:0] live,
    input logic [2*NCH-1:0] mask_q
);

    logic clr_in;
    assign clr_in = (rd_stb && rd_clear) || mask_we;

    AST_MASKED_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((rd_data ^ $past(live)) & $past(mask_q)) == '0)); // R6

    AST_UNMASKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |=> (((rd_data ^ $past(rd_data)) & ~$past(mask_q)) == '0)); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !clr_in) |=> !irq_n); // R7

    AST_CLEAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_in |=> irq_n); // R8

    AST_BIT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && !clr_in && (((live ^ rd_data) & ~mask_q) != '0)) |=> !irq_n); // R4

    AST_TX_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && !clr_in && ((tx_chg & tx_arm) != '0)) |=> !irq_n); // R5

    AST_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && ((live ^ rd_data) & ~mask_q) == '0 && (tx_chg & tx_arm) == '0)
            |=> irq_n); // R11

endmodule

bind rt_status_irq rtsr_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_chg   (tx_chg),
    .tx_arm   (tx_arm),
    .rd_stb   (rd_stb),
    .rd_clear (rd_clear),
    .mask_we  (mask_we),
    .rd_data  (rd_data),
    .irq_n    (irq_n),
    .live     (live),
    .mask_q   (st_q.mask)
);

// File: tb/test_rt_status_irq.sv
module test_rt_status_irq;

    localparam int NCH = 4;
    localparam int W   = 2*NCH;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] cd_a, cd_b, cd_alt, tx_chg, tx_arm;
    logic           alt_mode, rd_stb, rd_clear, mask_we;
    logic [W-1:0]   mask_wdata, rd_data;
    logic           irq_n;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [W-1:0] m_stat, m_mask;
    logic         m_irq;

    always #10 clk = ~clk;

    rt_status_irq #(.NCH(NCH)) i_rt_status_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cd_a       (cd_a),
        .cd_b       (cd_b),
        .cd_alt     (cd_alt),
        .alt_mode   (alt_mode),
        .tx_chg     (tx_chg),
        .tx_arm     (tx_arm),
        .rd_stb     (rd_stb),
        .rd_clear   (rd_clear),
        .rd_data    (rd_data),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .irq_n      (irq_n)
    );

    function automatic logic [W-1:0] f_live();
        logic [W-1:0] v;
        for (int ch = 0; ch < NCH; ch++) begin
            v[2*ch]     = cd_a[ch];
            v[2*ch + 1] = alt_mode ? cd_alt[ch] : cd_b[ch];
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    // Reference model step from the requirements, then one clock, then compare.
    task automatic tick();
        logic [W-1:0] lv;
        logic         clr, evt;
        lv  = f_live();
        clr = (rd_stb && rd_clear) || mask_we;
        evt = !m_irq && (((lv ^ m_stat) & ~m_mask) != '0 || (tx_chg & tx_arm) != '0);
        if (m_irq || clr) m_stat = (m_stat & ~m_mask) | (lv & m_mask);
        else              m_stat = lv;
        if (clr)      m_irq = 1'b0;
        else if (evt) m_irq = 1'b1;
        if (mask_we) m_mask = mask_wdata;
        @(posedge clk);
        @(negedge clk);
        chk("R1/R6 status word", rd_data, m_stat);
        chk("R4/R7 interrupt", {{(W-1){1'b0}}, irq_n}, {{(W-1){1'b0}}, ~m_irq});
    endtask

    task automatic idle_ctl();
        rd_stb = 1'b0; rd_clear = 1'b0; mask_we = 1'b0; tx_chg = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cd_a = '0; cd_b = '0; cd_alt = '0; alt_mode = 1'b0;
        tx_arm = '0; mask_wdata = '0;
        idle_ctl();
        m_stat = '0; m_mask = '1; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 reset status", rd_data, '0);
        chk("R3 reset irq_n", {7'b0, irq_n}, 8'h01);
        rst_n = 1'b1;
        tick();

        // All bits masked after reset: input changes show but never interrupt.
        cd_a = 4'b0101;
        tick();
        chk("R1 A-bit layout", rd_data, 8'h11);
        chk("R11 masked change", {7'b0, irq_n}, 8'h01);

        cd_b = 4'b0011; cd_alt = 4'b1100;
        tick();
        chk("R2 secondary source", rd_data, 8'h1B);
        alt_mode = 1'b1;
        tick();
        chk("R2 alternate source", rd_data, 8'hB1);

        mask_we = 1'b1; mask_wdata = 8'h00;
        tick();
        chk("R9 mask write no irq", {7'b0, irq_n}, 8'h01);
        idle_ctl();

        cd_a[1] = 1'b1;
        tick();
        chk("R4 unmasked change", {7'b0, irq_n}, 8'h00);
        chk("R4 captured word", rd_data, 8'hB5);
        cd_a[1] = 1'b0;
        tick();
        chk("R6 frozen word", rd_data, 8'hB5);
        chk("R7 irq held", {7'b0, irq_n}, 8'h00);

        rd_stb = 1'b1; rd_clear = 1'b0;
        tick();
        chk("R8 plain read keeps irq", {7'b0, irq_n}, 8'h00);
        chk("R8 plain read keeps word", rd_data, 8'hB5);
        rd_clear = 1'b1;
        tick();
        chk("R8 clearing read", {7'b0, irq_n}, 8'h01);
        chk("R10 held through clear", rd_data, 8'hB5);
        idle_ctl();
        tick();
        chk("R10 reassert", {7'b0, irq_n}, 8'h00);
        chk("R10 new capture", rd_data, 8'hB1);
        rd_stb = 1'b1; rd_clear = 1'b1;
        tick();
        idle_ctl();
        tick();
        chk("R10 no pending diff", {7'b0, irq_n}, 8'h01);

        tx_chg = 4'b0010;
        tick();
        chk("R5 unarmed ignored", {7'b0, irq_n}, 8'h01);
        tx_arm = 4'b0010;
        tick();
        chk("R5 armed event", {7'b0, irq_n}, 8'h00);
        rd_stb = 1'b1; rd_clear = 1'b1;
        tick();
        idle_ctl();
        tick();
        chk("R10 tx dropped on clear", {7'b0, irq_n}, 8'h01);

        mask_we = 1'b1; mask_wdata = 8'h0F;
        tick();
        idle_ctl();
        cd_a[0] = 1'b0;
        tick();
        chk("R11 masked bit quiet", {7'b0, irq_n}, 8'h01);
        chk("R11 masked bit shown", rd_data, 8'hB0);
        cd_a[2] = 1'b0;
        tick();
        chk("R4 upper unmasked", {7'b0, irq_n}, 8'h00);
        cd_a[0] = 1'b1; cd_a[2] = 1'b1;
        tick();
        chk("R6 mixed freeze", rd_data, 8'hA1);
        mask_we = 1'b1; mask_wdata = 8'h0F;
        tick();
        chk("R9 mask write clears", {7'b0, irq_n}, 8'h01);
        idle_ctl();
        tick();

        // Random phase against the model.
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4000; i++) begin
            idle_ctl();
            if ($urandom_range(3) == 0) cd_a   = cd_a   ^ NCH'($urandom_range(15));
            if ($urandom_range(3) == 0) cd_b   = cd_b   ^ NCH'($urandom_range(15));
            if ($urandom_range(3) == 0) cd_alt = cd_alt ^ NCH'($urandom_range(15));
            if ($urandom_range(31) == 0) alt_mode = ~alt_mode;
            if ($urandom_range(15) == 0) tx_arm = NCH'($urandom_range(15));
            if ($urandom_range(5) == 0)  tx_chg = NCH'($urandom_range(15));
            if ($urandom_range(5) == 0) begin
                rd_stb = 1'b1; rd_clear = 1'($urandom_range(1));
            end
            if ($urandom_range(39) == 0) begin
                mask_we = 1'b1; mask_wdata = W'($urandom_range(255));
            end
            tick();
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule